// File: doc/BRIEF.md
# Byte-Serial Program Memory Loader

This block lets a host fill a program memory of 32-bit instruction words through a register port that is only one byte wide. The host selects a starting word by writing a low and a high address register. It then streams bytes into a single data window. Four consecutive window writes are gathered, least significant byte first, into one word. The word is stored on the fourth byte, and the word cursor then moves to the next location. Reads through the same window walk the stored words byte by byte under the same cursor rules, so a loaded program can be verified with the same access pattern that loaded it.

A control register holds a load-enable bit, which gates window writes, and a self-clearing clear bit, which sends the cursor back to word 0. The memory sits inside the block as a synchronous array with one write port and one registered read port. It is written so that it can map onto block RAM. Execution of the stored program is outside this block.

The register selector uses these codes: 0 = control, 1 = data window, 2 = address low, 3 = address high. In the control register, bit 0 is load-enable and bit 1 is clear. Only one access happens per cycle. If `acc_wr` and `acc_rd` are both high, the write takes effect and the read is dropped.

Top module: `prog_ram_loader`

## Requirements
- R1: After reset, `acc_rdata` is 0, load-enable is 0, and the word address is 0. Reading the control register (selector 0) returns 0, and both address registers (selectors 2 and 3) return 0.
- R2: With load-enable set, four window writes (selector 1) to word address A store the word {byte3, byte2, byte1, byte0} at A. The first byte written is byte0, in bits 7:0.
- R3: The word address stays the same after the first, second and third window bytes. It increases by one only after the fourth byte.
- R4: The word address is 9 bits: address-low bits 7:0 plus bit 0 of address-high. Bits 7:1 of an address-high write are ignored, and reading address-high returns 0 in bits 7:1.
- R5: While load-enable is 0, window writes leave the memory unchanged and do not advance the byte lane or the word address.
- R6: Writing the control register with bit 1 set returns the word address and the byte lane to 0. Bit 1 reads back as 0, and bit 0 of the same write sets load-enable.
- R7: A write to either address register returns the byte lane to 0. The next window access therefore uses byte0 of the new word.
- R8: A window read returns the byte of the addressed word selected by the current lane, on `acc_rdata` one cycle after the request. It advances the lane and the word address by the same rules as a write, whatever the state of load-enable, and back-to-back reads are allowed.
- R9: The word address wraps from 511 to 0 when the lane of word 511 that holds byte3 is accessed.
- R10: `acc_rdata` holds its value in every cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_sel | input | 2 | Register selector (0 control, 1 window, 2 address low, 3 address high) |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Registered read data, valid the cycle after a read |

## Verification
The hardest case to reach from the ports is the read cursor running through the end of the memory. Here the prefetched word must track a cursor that wraps from 511 to 0, while the lane counter is reset part-way through a word by address writes or a clear. Reaching it requires a memory filled with known contents. The stimulus therefore first loads all 512 words in one stream, which also wraps the address on the write side. It then places the cursor at word 510 through both address registers and reads back to back across the wrap. A seeded random mix of window accesses, address writes and control writes (some with load-enable off) then runs against a bench model of the cursor and memory.

// File: rtl/prl_pkg.sv
package prl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_ALO  = 2'd2,
    SEL_AHI  = 2'd3
  } reg_sel_e;

  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;
endpackage

// File: rtl/prl_ram.sv
module prl_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/prl_cursor.sv
module prl_cursor #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       lo_wr,
  input  logic                       hi_wr,
  input  logic [prl_pkg::BYTE_W-1:0] wbyte,
  input  logic                       step,
  output logic [ADDR_W-1:0]          addr,
  output logic [ADDR_W-1:0]          addr_nxt,
  output logic [$clog2(LANES)-1:0]   lane
);
  localparam int BW     = prl_pkg::BYTE_W;
  localparam int HI_W   = ADDR_W - BW;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST_L   = LANE_W'(LANES - 1);
  localparam logic [LANE_W-1:0] LANE_ONE = LANE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [LANE_W-1:0] lane_nxt;

  // next-state is exported so the RAM read port can prefetch the word
  always_comb begin
    addr_nxt = addr;
    lane_nxt = lane;
    if (rst || clr) begin
      addr_nxt = '0;
      lane_nxt = '0;
    end else if (lo_wr) begin
      addr_nxt[BW-1:0] = wbyte;
      lane_nxt         = '0;
    end else if (hi_wr) begin
      addr_nxt[ADDR_W-1:BW] = wbyte[HI_W-1:0];
      lane_nxt              = '0;
    end else if (step) begin
      if (lane == LAST_L) begin
        lane_nxt = '0;
        addr_nxt = addr + ADDR_ONE;
      end else begin
        lane_nxt = lane + LANE_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    addr <= addr_nxt;
    lane <= lane_nxt;
  end

  // R3: a step before the last lane must not move the word address
  a_r3_hold_mid_word: assert property (@(posedge clk) disable iff (rst)
    (step && lane != LAST_L && !clr && !lo_wr && !hi_wr) |=> $stable(addr));

  // R9: stepping out of the top word lands on word 0
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (step && lane == LAST_L && addr == ADDR_MAX && !clr && !lo_wr && !hi_wr)
      |=> (addr == '0));

  // R6: clear empties both cursor fields
  a_r6_clear_cursor: assert property (@(posedge clk) disable iff (rst)
    clr |=> (addr == '0 && lane == '0));

  // R7: address register writes restart the lane
  a_r7_lane_restart: assert property (@(posedge clk) disable iff (rst)
    (lo_wr || hi_wr) |=> (lane == '0));
endmodule

// File: rtl/prl_assembler.sv
module prl_assembler #(
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             fire,
  input  logic [$clog2(LANES)-1:0]         lane,
  input  logic [prl_pkg::BYTE_W-1:0]       wbyte,
  output logic                             ram_we,
  output logic [LANES*prl_pkg::BYTE_W-1:0] ram_wdata
);
  localparam int BW     = prl_pkg::BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int LAST   = LANES - 1;

  // lower lanes are staged; the top lane goes straight into the word
  for (genvar g = 0; g < LAST; g++) begin : g_stage
    logic [BW-1:0] held;
    always_ff @(posedge clk) begin
      if (rst)                                   held <= '0;
      else if (fire && lane == LANE_W'(g))       held <= wbyte;
    end
    assign ram_wdata[g*BW +: BW] = held;
  end

  assign ram_wdata[LAST*BW +: BW] = wbyte;
  assign ram_we = fire && (lane == LANE_W'(LAST));
endmodule

// File: rtl/prl_regif.sv
module prl_regif #(
  parameter int ADDR_W = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_wr,
  input  logic                       acc_rd,
  input  logic [1:0]                 acc_sel,
  input  logic [prl_pkg::BYTE_W-1:0] acc_wdata,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [prl_pkg::BYTE_W-1:0] win_byte,
  output logic                       load_en,
  output logic                       clr,
  output logic                       lo_wr,
  output logic                       hi_wr,
  output logic                       win_wr,
  output logic                       win_rd,
  output logic [prl_pkg::BYTE_W-1:0] acc_rdata
);
  import prl_pkg::*;

  localparam int HI_W = ADDR_W - BYTE_W;

  reg_sel_e sel;
  logic     rd_ok;
  logic     ctrl_wr;

  assign sel     = reg_sel_e'(acc_sel);
  assign rd_ok   = acc_rd && !acc_wr;
  assign ctrl_wr = acc_wr && sel == SEL_CTRL;
  assign clr     = ctrl_wr && acc_wdata[CTRL_CLR_BIT];
  assign lo_wr   = acc_wr && sel == SEL_ALO;
  assign hi_wr   = acc_wr && sel == SEL_AHI;
  assign win_wr  = acc_wr && sel == SEL_WIN;
  assign win_rd  = rd_ok && sel == SEL_WIN;

  always_ff @(posedge clk) begin
    if (rst)          load_en <= 1'b0;
    else if (ctrl_wr) load_en <= acc_wdata[CTRL_LOAD_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
    end else if (rd_ok) begin
      unique case (sel)
        SEL_CTRL: acc_rdata <= {{(BYTE_W-1){1'b0}}, load_en};
        SEL_WIN:  acc_rdata <= win_byte;
        SEL_ALO:  acc_rdata <= addr[BYTE_W-1:0];
        SEL_AHI:  acc_rdata <= {{(BYTE_W-HI_W){1'b0}}, addr[ADDR_W-1:BYTE_W]};
        default:  acc_rdata <= '0;
      endcase
    end
  end

  // R10: read data only changes after a read request
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(acc_rdata));
endmodule

// File: rtl/prog_ram_loader.sv
module prog_ram_loader #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [1:0] acc_sel,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata
);
  localparam int BW     = prl_pkg::BYTE_W;
  localparam int WORD_W = LANES * BW;
  localparam int LANE_W = $clog2(LANES);

  logic              load_en, clr, lo_wr, hi_wr, win_wr, win_rd, step;
  logic [ADDR_W-1:0] addr, addr_nxt;
  logic [LANE_W-1:0] lane;
  logic              ram_we;
  logic [WORD_W-1:0] ram_wdata, ram_q;
  logic [BW-1:0]     win_byte;

  assign step = (win_wr && load_en) || win_rd;

  prl_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .addr(addr),
    .win_byte(win_byte), .load_en(load_en), .clr(clr), .lo_wr(lo_wr),
    .hi_wr(hi_wr), .win_wr(win_wr), .win_rd(win_rd), .acc_rdata(acc_rdata)
  );

  prl_cursor #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cursor (
    .clk(clk), .rst(rst), .clr(clr), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .wbyte(acc_wdata), .step(step), .addr(addr), .addr_nxt(addr_nxt),
    .lane(lane)
  );

  prl_assembler #(.LANES(LANES)) u_asm (
    .clk(clk), .rst(rst), .fire(win_wr && load_en), .lane(lane),
    .wbyte(acc_wdata), .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  // read port follows the next cursor, so ram_q always holds mem[addr]
  prl_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(addr), .wdata(ram_wdata),
    .raddr(addr_nxt), .rdata(ram_q)
  );

  always_comb begin
    win_byte = '0;
    for (int i = 0; i < LANES; i++)
      if (lane == LANE_W'(i)) win_byte = ram_q[i*BW +: BW];
  end

  // R5: with loading disabled a window write never reaches the memory
  a_r5_gated_write: assert property (@(posedge clk) disable iff (rst)
    (win_wr && !load_en) |-> !ram_we);

  // R2: a commit only happens on a loading write of the top lane
  a_r2_commit_source: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (win_wr && load_en && lane == LANE_W'(LANES - 1)));
endmodule

// File: tb/tb_prog_ram_loader.sv
`timescale 1ns/1ps
module tb_prog_ram_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_wr = 1'b0, acc_rd = 1'b0;
  logic [1:0] acc_sel = 2'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic [7:0] acc_rdata;

  int tests = 0, fails = 0;

  localparam logic [1:0] S_CTRL = 2'd0, S_WIN = 2'd1, S_ALO = 2'd2, S_AHI = 2'd3;

  prog_ram_loader dut (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  always #4 clk = ~clk;

  // bench model of cursor, staging and memory
  logic [31:0] mem_m [512];
  logic [8:0]  m_addr;
  logic [1:0]  m_lane;
  logic        m_load;
  logic [7:0]  m_stage [3];

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h2545_F491) ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] sel);
    case (sel)
      S_CTRL:  return {7'd0, m_load};
      S_WIN:   return mem_m[m_addr][m_lane*8 +: 8];
      S_ALO:   return m_addr[7:0];
      default: return {7'd0, m_addr[8]};
    endcase
  endfunction

  task automatic m_advance();
    if (m_lane == 2'd3) begin m_lane = 2'd0; m_addr = m_addr + 9'd1; end
    else m_lane = m_lane + 2'd1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs are set at a falling edge and left active for one rising edge
  task automatic acc(input bit wr, input bit rd, input logic [1:0] sel,
                     input logic [7:0] d);
    acc_wr = wr; acc_rd = rd; acc_sel = sel; acc_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    acc_wr = 1'b0; acc_rd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic [7:0] d);
    acc(1'b1, 1'b0, sel, d);
    case (sel)
      S_CTRL: begin
        m_load = d[0];
        if (d[1]) begin m_addr = '0; m_lane = '0; end
      end
      S_ALO: begin m_addr[7:0] = d; m_lane = '0; end
      S_AHI: begin m_addr[8] = d[0]; m_lane = '0; end
      default: if (m_load) begin
        if (m_lane == 2'd3)
          mem_m[m_addr] = {d, m_stage[2], m_stage[1], m_stage[0]};
        else
          m_stage[m_lane] = d;
        m_advance();
      end
    endcase
  endtask

  task automatic do_rd(input logic [1:0] sel, input string tag);
    logic [7:0] exp;
    exp = m_read(sel);
    acc(1'b0, 1'b1, sel, 8'h00);
    check(acc_rdata === exp, tag, 32'(acc_rdata), 32'(exp));
    if (sel == S_WIN) m_advance();
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) do_wr(S_WIN, w[b*8 +: 8]);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd20240611));
    m_addr = '0; m_lane = '0; m_load = 1'b0;
    for (int i = 0; i < 3; i++) m_stage[i] = '0;
    for (int i = 0; i < 512; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(acc_rdata === 8'h00, "R1 rdata after reset", 32'(acc_rdata), 0);
    do_rd(S_CTRL, "R1 ctrl after reset");
    do_rd(S_ALO,  "R1 addr low after reset");
    do_rd(S_AHI,  "R1 addr high after reset");

    // R3: address holds until the fourth byte
    do_wr(S_CTRL, 8'h01);
    mem_m[0] = pat(0);
    for (int b = 0; b < 3; b++) begin
      do_wr(S_WIN, pat(0) >> (b*8));
      do_rd(S_ALO, "R3 address before fourth byte");
    end
    do_wr(S_WIN, pat(0) >> 24);
    do_rd(S_ALO, "R3 address after fourth byte");

    // R2 + R9: stream the rest of the memory, write side wraps to 0
    for (int i = 1; i < 512; i++) wr_word(pat(i));
    do_rd(S_ALO, "R9 write-side wrap low");
    do_rd(S_AHI, "R9 write-side wrap high");

    // R4: high register only uses bit 0
    do_wr(S_AHI, 8'hFF);
    do_wr(S_ALO, 8'hFE);
    do_rd(S_AHI, "R4 high address readback");
    do_rd(S_ALO, "R4 low address readback");

    // R8 + R9 + R2: back-to-back reads across the top of memory
    for (int k = 0; k < 12; k++) do_rd(S_WIN, "R8 R9 R2 read across wrap");
    idle(1);

    // R10: data stays after the read stops
    hold = acc_rdata;
    idle(3);
    check(acc_rdata === hold, "R10 rdata held", 32'(acc_rdata), 32'(hold));

    // R7: address write mid-word restarts the lane
    do_rd(S_WIN, "R8 partial read");
    do_rd(S_WIN, "R8 partial read");
    do_wr(S_ALO, 8'h05);
    do_rd(S_WIN, "R7 lane0 after address write");
    do_rd(S_WIN, "R7 lane1 after address write");

    // R5: loading disabled leaves memory and cursor untouched
    do_wr(S_CTRL, 8'h00);
    do_wr(S_ALO, 8'h07);
    for (int b = 0; b < 5; b++) do_wr(S_WIN, 8'hC3);
    do_rd(S_ALO, "R5 address unchanged");
    for (int b = 0; b < 4; b++) do_rd(S_WIN, "R5 word unchanged");

    // R6: clear bit restarts cursor, load bit taken from same write
    do_wr(S_CTRL, 8'h01);
    do_wr(S_ALO, 8'h23);
    do_wr(S_AHI, 8'h01);
    do_wr(S_WIN, 8'h11);
    do_wr(S_WIN, 8'h22);
    do_wr(S_CTRL, 8'h03);
    do_rd(S_ALO,  "R6 low address cleared");
    do_rd(S_AHI,  "R6 high address cleared");
    do_rd(S_CTRL, "R6 clear bit reads zero");
    wr_word(32'hDEAD_BEEF);
    do_wr(S_CTRL, 8'h03);
    for (int b = 0; b < 4; b++) do_rd(S_WIN, "R6 R2 word at 0 after clear");

    // random mix against the model
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 6)       do_wr(S_WIN, 8'($urandom));
      else if (r < 11) do_rd(S_WIN, "R8 R2 random window read");
      else if (r == 11) do_wr(S_ALO, 8'($urandom));
      else if (r == 12) do_wr(S_AHI, 8'($urandom));
      else if (r == 13) do_wr(S_CTRL, ($urandom % 8 == 0) ? 8'h03 : 8'($urandom % 2));
      else if (r == 14) do_rd(2'($urandom % 4), "R4 R5 R6 random register read");
      else idle(1);
    end
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule